// File: doc/BRIEF.md
# Timer Channel Interrupt Router

This block sits behind the comparators of a multi-channel timer. For every channel it holds a 64-bit configuration word and a 64-bit message word, and it turns a comparator match into exactly one interrupt event. A match can produce one of three things. It can produce a one-cycle edge pulse on one of 32 interrupt pins. It can produce a level interrupt that stays high until it is cleared. It can produce a message-signalled request, which carries a 32-bit address and 32-bit data and is offered on a valid/ready handshake.

The block enforces consistency on configuration writes. Capability fields are read-only. The pin chosen by a write must appear in the channel's allowed-pin mask. Whenever a configuration change would leave a level interrupt stranded, the block clears that interrupt. Software clears level interrupts with a write-one-to-clear vector. A combinational read port returns either stored word of any channel.

Top module: `irq_route_top`

## Requirements
- R1: Configuration bit 2 enables a channel's interrupt. While it is 0, a match changes no pin, raises no message request and leaves the status bit at 0.
- R2: While a channel's status bit is 1, a further match on that channel has no effect. A software clear and a match in the same cycle therefore leave the status bit at 0.
- R3: Message mode is in force only when capability bit 15 and enable bit 14 are both 1. In this mode a match sets `msg_valid_o` on the following cycle, with `msg_addr_o` equal to message word bits 63:32 and `msg_data_o` equal to bits 31:0. The request is held until `msg_ready_i` is accepted. A match arriving while the request is outstanding and not granted adds no second request.
- R4: The route is configuration bits 13:9. Route 0, or any channel in message mode, gives no pin activity, and pin 0 never toggles.
- R5: With trigger bit 1 at 0, a match gives a pulse of exactly one cycle on `pin_pulse_o[route]` in the cycle after the match, and the status bit is unchanged. With trigger bit 1 at 1, the status bit is set and `pin_level_o[route]` stays high from the next cycle until the status bit is cleared.
- R6: A configuration write merges data bytes selected by `wr_be_i`. Bits 63:32, 15, 5 and 4 keep their previous values, and bit 8 always reads 0.
- R7: If a written nonzero route names a pin whose bit in the allowed mask (configuration bit 32+route) is 0, the route is stored as 0.
- R8: At reset, every configuration word reads as follows. Bits 63:32 hold pins 24–31 when PINCOUNT ≥ 32, the four pins just below PINCOUNT when PINCOUNT ≥ 20, and no pins otherwise. Bits 15 and 4 are 1 and all other bits are 0. Message words, status bits and all outputs are 0.
- R9: A configuration write clears the channel's status bit, and with it the level pin, when it leaves the interrupt disabled, enables message mode, selects edge trigger or changes the route. This takes priority over a match in the same cycle. A write that changes none of these keeps the status bit.
- R10: A 1 on `sts_clr_i[c]` clears status bit c and its level pin on the next cycle. A status bit rises only in the cycle after a match on that channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| match_i | input | NCH | One comparator match strobe per channel |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 configuration word, 1 message word |
| wr_ch_i | input | CHW | Channel written |
| wr_data_i | input | 64 | Write data |
| wr_be_i | input | 8 | Byte enables for the write |
| sts_clr_i | input | NCH | Write-one-to-clear for the status bits |
| rd_sel_i | input | 1 | Read target: 0 configuration word, 1 message word |
| rd_ch_i | input | CHW | Channel read |
| rd_data_o | output | 64 | Read data (combinational) |
| sts_o | output | NCH | Level status bits |
| pin_pulse_o | output | 32 | One-cycle edge pulses per pin |
| pin_level_o | output | 32 | Level interrupt per pin |
| msg_valid_o | output | 1 | Message request valid |
| msg_ready_i | input | 1 | Message request accepted |
| msg_addr_o | output | 32 | Message address |
| msg_data_o | output | 32 | Message data |

## Verification
Two pairs of functions can land in the same cycle on one channel. The first pair is a comparator match and a configuration write that strands the level interrupt. The second is a match and a software status clear. The bench provokes the first by raising the match strobe in the very cycle that a write moves the route. It checks that the status bit and the level pin stay low. It then repeats the case with a write that touches only a neutral bit, and expects the status bit to come up. For the clear, the bench issues match and clear together twice: once with status already set, expecting 0, and once with status at 0, expecting 1.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    localparam int CFG_W   = 64;
    localparam int ROUTE_W = 5;
    localparam int NPINS   = 1 << ROUTE_W;

    // Configuration word bit positions
    localparam int B_TRIG   = 1;
    localparam int B_EN     = 2;
    localparam int B_PERCAP = 4;
    localparam int B_SIZE   = 5;
    localparam int B_M32    = 8;
    localparam int B_RT_LO  = 9;
    localparam int B_MSGEN  = 14;
    localparam int B_MSGCAP = 15;
    localparam int MASK_LO  = 32;

    localparam logic [CFG_W-1:0] RO_BITS = 64'hFFFF_FFFF_0000_8030;

    typedef struct packed {
        logic               en;
        logic               level;
        logic               msg;
        logic [ROUTE_W-1:0] route;
    } ch_mode_t;

    function automatic logic [31:0] reset_allow(input int pc);
        if (pc >= 32)      return 32'hFF00_0000;
        else if (pc >= 20) return 32'hF << (pc - 4);
        else               return 32'h0;
    endfunction

    function automatic logic [CFG_W-1:0] reset_cfg(input int pc);
        logic [CFG_W-1:0] r;
        r = '0;
        r[CFG_W-1:MASK_LO] = reset_allow(pc);
        r[B_PERCAP] = 1'b1;
        r[B_MSGCAP] = 1'b1;
        return r;
    endfunction

    function automatic logic [CFG_W-1:0] merge_bytes(input logic [CFG_W-1:0] old_w,
                                                      input logic [CFG_W-1:0] data,
                                                      input logic [7:0]       be);
        logic [CFG_W-1:0] r;
        r = old_w;
        for (int b = 0; b < 8; b++)
            if (be[b]) r[8*b +: 8] = data[8*b +: 8];
        return r;
    endfunction

    function automatic logic [CFG_W-1:0] sanitize_cfg(input logic [CFG_W-1:0] old_c,
                                                       input logic [CFG_W-1:0] wr_c);
        logic [CFG_W-1:0]   n;
        logic [ROUTE_W-1:0] rt;
        n = (wr_c & ~RO_BITS) | (old_c & RO_BITS);
        n[B_M32] = 1'b0;
        rt = n[B_RT_LO +: ROUTE_W];
        if (rt != '0 && !n[MASK_LO + int'(rt)])
            n[B_RT_LO +: ROUTE_W] = '0;
        return n;
    endfunction

    function automatic ch_mode_t decode_mode(input logic [CFG_W-1:0] c);
        ch_mode_t m;
        m.en    = c[B_EN];
        m.level = c[B_TRIG];
        m.msg   = c[B_MSGCAP] & c[B_MSGEN];
        m.route = m.msg ? '0 : c[B_RT_LO +: ROUTE_W];
        return m;
    endfunction

endpackage

// File: rtl/irq_chan_regs.sv
module irq_chan_regs
    import irq_route_pkg::*;
#(
    parameter int PINCOUNT = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_cfg_i,
    input  logic             wr_msg_i,
    input  logic [CFG_W-1:0] wr_data_i,
    input  logic [7:0]       wr_be_i,
    output logic [CFG_W-1:0] cfg_o,
    output logic [CFG_W-1:0] msg_o,
    output logic             cfg_clr_o
);
    logic [CFG_W-1:0] cfg_n;
    ch_mode_t         old_m, new_m;

    always_comb begin
        cfg_n = sanitize_cfg(cfg_o, merge_bytes(cfg_o, wr_data_i, wr_be_i));
        old_m = decode_mode(cfg_o);
        new_m = decode_mode(cfg_n);
        // A write that would strand a level interrupt drops it
        cfg_clr_o = wr_cfg_i && (!new_m.en || new_m.msg || !new_m.level ||
                                 (new_m.route != old_m.route));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_o <= reset_cfg(PINCOUNT);
            msg_o <= '0;
        end else begin
            if (wr_cfg_i) cfg_o <= cfg_n;
            if (wr_msg_i) msg_o <= merge_bytes(msg_o, wr_data_i, wr_be_i);
        end
    end
endmodule

// File: rtl/irq_chan_evt.sv
module irq_chan_evt
    import irq_route_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               match_i,
    input  ch_mode_t           mode_i,
    input  logic               cfg_clr_i,
    input  logic               sw_clr_i,
    input  logic               gnt_i,
    output logic               sts_o,
    output logic               pulse_o,
    output logic [ROUTE_W-1:0] pulse_rt_o,
    output logic               pend_o
);
    logic fire, routed, set_lvl, set_pls, set_msg;

    always_comb begin
        fire    = match_i && mode_i.en && !sts_o;
        routed  = !mode_i.msg && (mode_i.route != '0);
        set_lvl = fire && routed && mode_i.level;
        set_pls = fire && routed && !mode_i.level;
        set_msg = fire && mode_i.msg;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sts_o      <= 1'b0;
            pulse_o    <= 1'b0;
            pulse_rt_o <= '0;
            pend_o     <= 1'b0;
        end else begin
            sts_o      <= (sts_o && !sw_clr_i && !cfg_clr_i) || (set_lvl && !cfg_clr_i);
            pulse_o    <= set_pls;
            pulse_rt_o <= mode_i.route;
            pend_o     <= set_msg || (pend_o && !gnt_i);
        end
    end
endmodule

// File: rtl/irq_msg_arb.sv
module irq_msg_arb
    import irq_route_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic [NCH-1:0]            pend_i,
    input  logic                      ready_i,
    input  logic [NCH-1:0][CFG_W-1:0] msg_i,
    output logic                      valid_o,
    output logic [31:0]               addr_o,
    output logic [31:0]               data_o,
    output logic [NCH-1:0]            gnt_o
);
    always_comb begin
        logic found;
        found  = 1'b0;
        gnt_o  = '0;
        addr_o = '0;
        data_o = '0;
        for (int c = 0; c < NCH; c++) begin
            if (pend_i[c] && !found) begin
                found    = 1'b1;
                addr_o   = msg_i[c][63:32];
                data_o   = msg_i[c][31:0];
                gnt_o[c] = ready_i;
            end
        end
        valid_o = found;
    end
endmodule

// File: rtl/irq_route_top.sv
module irq_route_top
    import irq_route_pkg::*;
#(
    parameter  int NCH      = 4,
    parameter  int PINCOUNT = 24,
    localparam int CHW      = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NCH-1:0]   match_i,
    input  logic             wr_en_i,
    input  logic             wr_sel_i,
    input  logic [CHW-1:0]   wr_ch_i,
    input  logic [63:0]      wr_data_i,
    input  logic [7:0]       wr_be_i,
    input  logic [NCH-1:0]   sts_clr_i,
    input  logic             rd_sel_i,
    input  logic [CHW-1:0]   rd_ch_i,
    output logic [63:0]      rd_data_o,
    output logic [NCH-1:0]   sts_o,
    output logic [31:0]      pin_pulse_o,
    output logic [31:0]      pin_level_o,
    output logic             msg_valid_o,
    input  logic             msg_ready_i,
    output logic [31:0]      msg_addr_o,
    output logic [31:0]      msg_data_o
);
    logic [NCH-1:0][CFG_W-1:0]   cfg_all, msg_all;
    logic [NCH-1:0]              cfg_clr, pulse, pend, gnt;
    logic [NCH-1:0][ROUTE_W-1:0] pulse_rt;
    ch_mode_t                    mode [NCH];

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic wr_hit;
        assign wr_hit  = wr_en_i && (wr_ch_i == CHW'(c));
        assign mode[c] = decode_mode(cfg_all[c]);

        irq_chan_regs #(.PINCOUNT(PINCOUNT)) u_regs (
            .clk       (clk),
            .rst       (rst),
            .wr_cfg_i  (wr_hit && !wr_sel_i),
            .wr_msg_i  (wr_hit && wr_sel_i),
            .wr_data_i (wr_data_i),
            .wr_be_i   (wr_be_i),
            .cfg_o     (cfg_all[c]),
            .msg_o     (msg_all[c]),
            .cfg_clr_o (cfg_clr[c])
        );

        irq_chan_evt u_evt (
            .clk        (clk),
            .rst        (rst),
            .match_i    (match_i[c]),
            .mode_i     (mode[c]),
            .cfg_clr_i  (cfg_clr[c]),
            .sw_clr_i   (sts_clr_i[c]),
            .gnt_i      (gnt[c]),
            .sts_o      (sts_o[c]),
            .pulse_o    (pulse[c]),
            .pulse_rt_o (pulse_rt[c]),
            .pend_o     (pend[c])
        );
    end

    irq_msg_arb #(.NCH(NCH)) u_arb (
        .pend_i  (pend),
        .ready_i (msg_ready_i),
        .msg_i   (msg_all),
        .valid_o (msg_valid_o),
        .addr_o  (msg_addr_o),
        .data_o  (msg_data_o),
        .gnt_o   (gnt)
    );

    always_comb begin
        pin_pulse_o = '0;
        pin_level_o = '0;
        for (int c = 0; c < NCH; c++) begin
            if (pulse[c]) pin_pulse_o[pulse_rt[c]] = 1'b1;
            if (sts_o[c]) pin_level_o[mode[c].route] = 1'b1;
        end
    end

    always_comb begin
        rd_data_o = '0;
        for (int c = 0; c < NCH; c++)
            if (rd_ch_i == CHW'(c))
                rd_data_o = rd_sel_i ? msg_all[c] : cfg_all[c];
    end
endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk #(
    parameter int NCH = 4
) (
    input logic           clk,
    input logic           rst,
    input logic [NCH-1:0] match_i,
    input logic [NCH-1:0] sts_o,
    input logic [31:0]    pin_pulse_o,
    input logic [31:0]    pin_level_o,
    input logic           msg_valid_o,
    input logic           msg_ready_i
);
    // R4
    pin0_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !pin_pulse_o[0] && !pin_level_o[0]);

    // R3
    msg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (msg_valid_o && !msg_ready_i) |=> msg_valid_o);

    // R10
    sts_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (sts_o & ~$past(sts_o) & ~$past(match_i)) == '0);

    // R5
    pulse_cause_chk: assert property (@(posedge clk) disable iff (rst)
        (pin_pulse_o != '0) |-> ($past(match_i) != '0));

    // R5
    pulse_count_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(pin_pulse_o) <= NCH);
endmodule

bind irq_route_top irq_route_chk #(.NCH(NCH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .match_i     (match_i),
    .sts_o       (sts_o),
    .pin_pulse_o (pin_pulse_o),
    .pin_level_o (pin_level_o),
    .msg_valid_o (msg_valid_o),
    .msg_ready_i (msg_ready_i)
);

// File: tb/tb_irq_route_top.sv
module tb_irq_route_top;
    localparam int NCH = 4;
    localparam int CHW = 2;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [NCH-1:0]   match_i = '0;
    logic             wr_en_i = 1'b0, wr_sel_i = 1'b0;
    logic [CHW-1:0]   wr_ch_i = '0;
    logic [63:0]      wr_data_i = '0;
    logic [7:0]       wr_be_i = '0;
    logic [NCH-1:0]   sts_clr_i = '0;
    logic             rd_sel_i = 1'b0;
    logic [CHW-1:0]   rd_ch_i = '0;
    logic [63:0]      rd_data_o;
    logic [NCH-1:0]   sts_o;
    logic [31:0]      pin_pulse_o, pin_level_o;
    logic             msg_valid_o;
    logic             msg_ready_i = 1'b0;
    logic [31:0]      msg_addr_o, msg_data_o;

    int n_chk = 0, n_fail = 0, cyc = 0;

    localparam logic [63:0] EN   = 64'h4;
    localparam logic [63:0] LVL  = 64'h2;
    localparam logic [63:0] NEU  = 64'h8;
    localparam logic [63:0] MSGE = 64'h4000;
    localparam logic [63:0] CAPS = {32'h00F0_0000, 32'h0000_8010};

    irq_route_top #(.NCH(NCH), .PINCOUNT(24)) dut (.*);

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual=%0d expected<20000 cycles", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    function automatic logic [63:0] rt(input int r);
        return 64'(r) << 9;
    endfunction

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input int ch, input logic [63:0] d, input logic [7:0] be);
        wr_en_i = 1'b1; wr_sel_i = sel; wr_ch_i = CHW'(ch); wr_data_i = d; wr_be_i = be;
        tick();
        wr_en_i = 1'b0;
    endtask

    task automatic rd(input logic sel, input int ch, output logic [63:0] d);
        rd_sel_i = sel; rd_ch_i = CHW'(ch); #1; d = rd_data_o;
    endtask

    task automatic hit(input logic [NCH-1:0] m);
        match_i = m; tick(); match_i = '0;
    endtask

    task automatic t_reset();
        logic [63:0] d;
        for (int c = 0; c < NCH; c++) begin
            rd(1'b0, c, d); check("R8 cfg reset", d, CAPS);
            rd(1'b1, c, d); check("R8 msg reset", d, 64'h0);
        end
        check("R8 sts/pins", {sts_o, pin_pulse_o, pin_level_o, msg_valid_o}, '0);
    endtask

    task automatic t_cfg_write();
        logic [63:0] d;
        wr(1'b0, 0, '1, 8'hFF);
        rd(1'b0, 0, d);
        check("R6 R7 full write", d, {32'h00F0_0000, 32'hFFFF_C0DF});
        wr(1'b0, 0, rt(20), 8'h02);
        rd(1'b0, 0, d);
        check("R6 byte mask", d, {32'h00F0_0000, 32'hFFFF_A8DF});
        wr(1'b0, 0, '0, 8'hFF);
        rd(1'b0, 0, d);
        check("R6 clear write", d, CAPS);
        wr(1'b0, 2, rt(5) | EN, 8'hFF);
        rd(1'b0, 2, d);
        check("R7 disallowed route", d, CAPS | EN);
        wr(1'b0, 2, rt(23) | EN, 8'hFF);
        rd(1'b0, 2, d);
        check("R7 allowed route", d, CAPS | EN | rt(23));
    endtask

    task automatic t_edge();
        wr(1'b0, 0, rt(21) | EN, 8'h03);
        hit(4'b0001);
        check("R5 edge pulse", pin_pulse_o, 32'h1 << 21);
        check("R5 edge sts", {sts_o, pin_level_o}, '0);
        tick();
        check("R5 pulse one cycle", pin_pulse_o, 32'h0);
    endtask

    task automatic t_level();
        wr(1'b0, 1, rt(22) | EN | LVL, 8'h03);
        hit(4'b0010);
        check("R5 level sts", sts_o, 4'b0010);
        check("R5 level pin", pin_level_o, 32'h1 << 22);
        check("R5 level no pulse", pin_pulse_o, 32'h0);
        tick(); tick(); tick();
        check("R5 level held", pin_level_o, 32'h1 << 22);
    endtask

    task automatic t_clear();
        match_i = 4'b0010; sts_clr_i = 4'b0010; tick(); match_i = '0; sts_clr_i = '0;
        check("R2 R10 match ignored while set", {sts_o, pin_level_o}, '0);
        match_i = 4'b0010; sts_clr_i = 4'b0010; tick(); match_i = '0; sts_clr_i = '0;
        check("R10 match with idle clear", sts_o, 4'b0010);
        sts_clr_i = 4'b0010; tick(); sts_clr_i = '0;
        check("R10 sw clear", {sts_o, pin_level_o}, '0);
    endtask

    task automatic t_quiet();
        wr(1'b0, 2, rt(23) | LVL, 8'h03);
        hit(4'b0100);
        check("R1 disabled", {sts_o, pin_level_o, pin_pulse_o, msg_valid_o}, '0);
        wr(1'b0, 2, EN | LVL, 8'h03);
        hit(4'b0100);
        check("R4 route zero level", {sts_o, pin_level_o}, '0);
        wr(1'b0, 2, EN, 8'h03);
        hit(4'b0100);
        check("R4 route zero edge", pin_pulse_o, 32'h0);
    endtask

    task automatic t_msg();
        wr(1'b1, 3, {32'hFEE0_1000, 32'h0000_0041}, 8'hFF);
        wr(1'b0, 3, EN | MSGE | rt(20), 8'hFF);
        hit(4'b1000);
        check("R3 msg valid", msg_valid_o, 1'b1);
        check("R3 msg addr", msg_addr_o, 32'hFEE0_1000);
        check("R3 msg data", msg_data_o, 32'h0000_0041);
        check("R3 R4 msg no pin", {pin_pulse_o, pin_level_o, sts_o}, '0);
        tick();
        hit(4'b1000);
        check("R3 msg held", msg_valid_o, 1'b1);
        msg_ready_i = 1'b1; tick();
        check("R3 msg granted", msg_valid_o, 1'b0);
        tick(); msg_ready_i = 1'b0;
        check("R3 no second request", msg_valid_o, 1'b0);
    endtask

    task automatic t_autoclr();
        wr(1'b0, 1, rt(22) | EN | LVL, 8'h03);
        hit(4'b0010);
        wr(1'b0, 1, rt(20) | EN | LVL, 8'h03);
        check("R9 route change", {sts_o, pin_level_o}, '0);
        hit(4'b0010);
        check("R9 set again", pin_level_o, 32'h1 << 20);
        wr(1'b0, 1, rt(20) | EN | LVL | NEU, 8'h03);
        check("R9 neutral write keeps", sts_o, 4'b0010);
        wr(1'b0, 1, rt(20) | LVL, 8'h03);
        check("R9 disable", {sts_o, pin_level_o}, '0);
        wr(1'b0, 1, rt(20) | EN | LVL, 8'h03);
        hit(4'b0010);
        wr(1'b0, 1, rt(20) | EN, 8'h03);
        check("R9 to edge", {sts_o, pin_level_o}, '0);
        wr(1'b0, 1, rt(20) | EN | LVL, 8'h03);
        hit(4'b0010);
        wr(1'b0, 1, rt(20) | EN | LVL | MSGE, 8'hFF);
        check("R9 to message", {sts_o, pin_level_o}, '0);
    endtask

    task automatic t_same_cycle();
        wr(1'b0, 1, rt(20) | EN | LVL, 8'hFF);
        match_i = 4'b0010;
        wr(1'b0, 1, rt(21) | EN | LVL, 8'h03);
        match_i = '0;
        check("R9 write beats match", {sts_o, pin_level_o}, '0);
        match_i = 4'b0010;
        wr(1'b0, 1, rt(21) | EN | LVL | NEU, 8'h03);
        match_i = '0;
        check("R9 neutral write with match", pin_level_o, 32'h1 << 21);
    endtask

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();
        t_reset();
        t_cfg_write();
        t_edge();
        t_level();
        t_clear();
        t_quiet();
        t_msg();
        t_autoclr();
        t_same_cycle();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule